// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects interrupt request lines from several peripherals and offers the processor one request at a time, together with a vector number that identifies the chosen source. Every source has a fixed priority, set by a parameter. A higher number means more urgent, and every priority must be at least 1. In the default build, source 0 is a printer with priority 2, source 1 is a disk with priority 4 and source 2 is a communication line with priority 5. The vector is a base value plus the source index.

A mode input selects how a second request is treated while a handler is running. In nested mode, a request more urgent than the level now in service preempts that handler. In sequential mode, nothing new is offered until every handler has ended, and waiting requests are then served in the order they arrived. An internal stack records the sources in service, so each end-of-interrupt strobe resumes the level that was interrupted. The processor takes the offered request by raising its acknowledge while the request is high.

Top module: `irq_nest_ctrl`

## Requirements
- R1: During and right after reset, `cpu_req` is 0, `vector` is 0 and `err_sticky` is 0.
- R2: A source becomes pending on a 0-to-1 transition of its `irq_in` bit. A line held high creates only one pending request.
- R3: In nested mode, the block offers the pending source of highest priority whose priority exceeds the current service level. On equal priority, the lower index wins. `vector` equals `VEC_BASE` plus that index while `cpu_req` is 1, and 0 otherwise.
- R4: In nested mode, a pending request whose priority is above that of the handler in service raises `cpu_req` while that handler is still in service.
- R5: In nested mode, a pending request whose priority is at or below the current service level is not offered. It stays pending.
- R6: `eoi` removes the most recent in-service source. The service level then falls back to the source it had preempted, or to 0 (idle) when the stack is empty.
- R7: In sequential mode, `cpu_req` stays 0 while any handler is in service. Requests arriving then stay pending.
- R8: In sequential mode with nothing in service, pending sources are offered in the order they arrived. Sources that become pending in the same cycle are ordered lowest index first.
- R9: Taking a request (`cpu_ack` high while `cpu_req` is high) clears its pending state and pushes it onto the in-service stack. It is offered again only after a new rising edge.
- R10: `eoi` with an empty in-service stack changes nothing else and sets `err_sticky`, which stays 1 until reset.
- R11: `cpu_ack` while `cpu_req` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | N | Peripheral request lines, bit i is source i |
| nest_mode | input | 1 | 1 selects nested preemption, 0 selects sequential service |
| cpu_ack | input | 1 | Processor accepts the offered request |
| eoi | input | 1 | End-of-interrupt strobe for the handler on top |
| cpu_req | output | 1 | A request is offered to the processor |
| vector | output | VW | Vector of the offered source, 0 when none |
| err_sticky | output | 1 | Set by an end-of-interrupt with nothing in service |

## Verification
`cpu_req` and `vector` come from registered state through logic only. They therefore follow a sampled rising edge one clock later, and they drop or change one clock after the edge that samples `cpu_ack` or `eoi`. A change of `nest_mode` affects them within the same cycle. `err_sticky` is a register that is set at the edge that samples the stray `eoi`. The bench changes inputs at the falling edge and reads outputs at the next falling edge, after exactly one rising edge. Every cycle it compares the outputs with a bench model that it has updated with the same inputs.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

  // how the current offer was chosen
  typedef enum logic [1:0] {
    PICK_NONE    = 2'd0,
    PICK_PRIO    = 2'd1,
    PICK_ARRIVAL = 2'd2
  } pick_kind_e;

  // index width for a count of n items, never zero
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // width able to hold 0..n
  function automatic int unsigned cnt_bits(input int unsigned n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/irq_nest_capture.sv
module irq_nest_capture #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] pend,
  output logic [N-1:0] accept
);

  logic [N-1:0] prev_q;
  logic [N-1:0] pend_q;
  logic [N-1:0] rise;

  // a rise is accepted unless the source stays pending this cycle
  assign rise   = irq_in & ~prev_q;
  assign accept = rise & ~(pend_q & ~clr_mask);
  assign pend   = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= irq_in;
      pend_q <= (pend_q & ~clr_mask) | accept;
    end
  end

endmodule

// File: rtl/irq_nest_arrival_q.sv
module irq_nest_arrival_q #(
  parameter int N  = 3,
  parameter int IW = 2,
  parameter int DW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  add_mask,
  input  logic          rm_valid,
  input  logic [IW-1:0] rm_idx,
  output logic          head_valid,
  output logic [IW-1:0] head_idx,
  output logic [DW-1:0] count
);

  logic [IW-1:0] idx_q [N];
  logic [IW-1:0] idx_n [N];
  logic [N-1:0]  vld_q;
  logic [N-1:0]  vld_n;

  // compact out the removed entry, then append arrivals lowest index first
  always_comb begin
    int pos;
    pos   = 0;
    idx_n = idx_q;
    vld_n = '0;
    for (int i = 0; i < N; i++) begin
      if (vld_q[i] && !(rm_valid && idx_q[i] == rm_idx)) begin
        for (int k = 0; k < N; k++) begin
          if (k == pos) begin
            idx_n[k] = idx_q[i];
            vld_n[k] = 1'b1;
          end
        end
        pos = pos + 1;
      end
    end
    for (int s = 0; s < N; s++) begin
      if (add_mask[s]) begin
        for (int k = 0; k < N; k++) begin
          if (k == pos) begin
            idx_n[k] = IW'(s);
            vld_n[k] = 1'b1;
          end
        end
        pos = pos + 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < N; i++) idx_q[i] <= '0;
    end else begin
      vld_q <= vld_n;
      idx_q <= idx_n;
    end
  end

  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++) count = count + DW'(vld_q[i]);
  end

  assign head_valid = vld_q[0];
  assign head_idx   = idx_q[0];

endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack #(
  parameter int N  = 3,
  parameter int IW = 2,
  parameter int DW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [IW-1:0] push_idx,
  input  logic          pop_req,
  output logic          top_valid,
  output logic [IW-1:0] top_idx,
  output logic [DW-1:0] depth,
  output logic          underflow
);

  logic [IW-1:0] stk_q [N];
  logic [DW-1:0] sp_q;
  logic          pop_fire;
  logic [DW-1:0] wr_ptr;

  assign pop_fire  = pop_req && (sp_q != '0);
  assign underflow = pop_req && (sp_q == '0);
  assign wr_ptr    = sp_q - DW'(pop_fire);
  assign top_valid = (sp_q != '0);
  assign depth     = sp_q;

  always_comb begin
    top_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (sp_q == DW'(i + 1)) top_idx = stk_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
      for (int i = 0; i < N; i++) stk_q[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (push && wr_ptr == DW'(i)) stk_q[i] <= push_idx;
      end
      sp_q <= wr_ptr + DW'(push && (wr_ptr < DW'(N)));
    end
  end

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl #(
  parameter int               N          = 3,
  parameter int               PW         = 3,
  parameter logic [N*PW-1:0]  PRIO_TABLE = {3'd5, 3'd4, 3'd2},
  parameter int               VW         = 8,
  parameter logic [VW-1:0]    VEC_BASE   = 8'h20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_in,
  input  logic          nest_mode,
  input  logic          cpu_ack,
  input  logic          eoi,
  output logic          cpu_req,
  output logic [VW-1:0] vector,
  output logic          err_sticky
);
  import irq_nest_pkg::*;

  localparam int IW = idx_bits(N);
  localparam int DW = cnt_bits(N);

  function automatic logic [PW-1:0] prio_of(input logic [IW-1:0] idx);
    logic [PW-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++) begin
      if (idx == IW'(i)) r = PRIO_TABLE[i*PW +: PW];
    end
    return r;
  endfunction

  // named internal events, also watched by the checker
  logic [N-1:0]  pend;
  logic [N-1:0]  accept;
  logic [N-1:0]  clr_mask;
  logic          head_valid;
  logic [IW-1:0] head_idx;
  logic [DW-1:0] q_count;
  logic          top_valid;
  logic [IW-1:0] top_idx;
  logic [DW-1:0] stk_depth;
  logic          underflow;
  logic [PW-1:0] cur_level;
  logic          nest_valid;
  logic [IW-1:0] nest_idx;
  logic [PW-1:0] nest_prio;
  pick_kind_e    pick_kind;
  logic          sel_valid;
  logic [IW-1:0] sel_idx;
  logic [PW-1:0] sel_prio;
  logic          take;
  logic          err_q;

  irq_nest_capture #(.N(N)) u_capture (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .clr_mask(clr_mask),
    .pend(pend), .accept(accept)
  );

  irq_nest_arrival_q #(.N(N), .IW(IW), .DW(DW)) u_order (
    .clk(clk), .rst_n(rst_n), .add_mask(accept), .rm_valid(take), .rm_idx(sel_idx),
    .head_valid(head_valid), .head_idx(head_idx), .count(q_count)
  );

  irq_nest_stack #(.N(N), .IW(IW), .DW(DW)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(take), .push_idx(sel_idx), .pop_req(eoi),
    .top_valid(top_valid), .top_idx(top_idx), .depth(stk_depth), .underflow(underflow)
  );

  assign cur_level = top_valid ? prio_of(top_idx) : '0;

  // highest priority above the current level, lowest index on a tie
  always_comb begin
    nest_valid = 1'b0;
    nest_idx   = '0;
    nest_prio  = '0;
    for (int i = 0; i < N; i++) begin
      if (pend[i] && prio_of(IW'(i)) > cur_level &&
          (!nest_valid || prio_of(IW'(i)) > nest_prio)) begin
        nest_valid = 1'b1;
        nest_idx   = IW'(i);
        nest_prio  = prio_of(IW'(i));
      end
    end
  end

  always_comb begin
    if (nest_mode) pick_kind = nest_valid ? PICK_PRIO : PICK_NONE;
    else           pick_kind = (head_valid && stk_depth == '0) ? PICK_ARRIVAL : PICK_NONE;
  end

  always_comb begin
    unique case (pick_kind)
      PICK_PRIO:    begin sel_valid = 1'b1; sel_idx = nest_idx; end
      PICK_ARRIVAL: begin sel_valid = 1'b1; sel_idx = head_idx; end
      default:      begin sel_valid = 1'b0; sel_idx = '0;       end
    endcase
  end

  assign sel_prio = prio_of(sel_idx);
  assign take     = sel_valid && cpu_ack;

  always_comb begin
    clr_mask = '0;
    for (int i = 0; i < N; i++) begin
      if (take && sel_idx == IW'(i)) clr_mask[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         err_q <= 1'b0;
    else if (underflow) err_q <= 1'b1;
  end

  assign cpu_req    = sel_valid;
  assign vector     = sel_valid ? VEC_BASE + VW'(sel_idx) : '0;
  assign err_sticky = err_q;

endmodule

// File: rtl/irq_nest_ctrl_checks.sv
module irq_nest_ctrl_checks #(
  parameter int            N        = 3,
  parameter int            PW       = 3,
  parameter int            VW       = 8,
  parameter logic [VW-1:0] VEC_BASE = 8'h20,
  parameter int            DW       = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          nest_mode,
  input logic          cpu_req,
  input logic          cpu_ack,
  input logic          eoi,
  input logic [VW-1:0] vector,
  input logic          err_sticky,
  input logic [N-1:0]  pend,
  input logic [DW-1:0] q_count,
  input logic [DW-1:0] stk_depth,
  input logic [PW-1:0] cur_level,
  input logic [PW-1:0] sel_prio,
  input logic          take
);

  p_vector_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> (int'(vector) >= int'(VEC_BASE) && int'(vector) < int'(VEC_BASE) + N));

  p_preempt_above_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (nest_mode && cpu_req) |-> (sel_prio > cur_level));

  p_stack_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(stk_depth) <= N);

  p_seq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!nest_mode && stk_depth != '0) |-> !cpu_req);

  p_order_book_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(q_count) == $countones(pend));

  p_take_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !eoi) |=> (stk_depth == $past(stk_depth) + 1'b1));

  p_err_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && stk_depth == '0) |=> err_sticky);

  p_err_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);

  p_stray_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && !cpu_req && !eoi) |=> $stable(stk_depth));

endmodule

bind irq_nest_ctrl irq_nest_ctrl_checks #(
  .N(N), .PW(PW), .VW(VW), .VEC_BASE(VEC_BASE), .DW(DW)
) u_checks (
  .clk(clk), .rst_n(rst_n), .nest_mode(nest_mode), .cpu_req(cpu_req),
  .cpu_ack(cpu_ack), .eoi(eoi), .vector(vector), .err_sticky(err_sticky),
  .pend(pend), .q_count(q_count), .stk_depth(stk_depth), .cur_level(cur_level),
  .sel_prio(sel_prio), .take(take)
);

// File: tb/irq_nest_ctrl_test.sv
module irq_nest_ctrl_test;
  localparam int N = 3;
  localparam logic [7:0] BASE = 8'h20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq = '0;
  logic mode = 1'b1, ack = 1'b0, eoi = 1'b0;
  logic req, err;
  logic [7:0] vec;

  always #5 clk = ~clk;

  irq_nest_ctrl #(.N(N), .PW(3), .PRIO_TABLE(9'b101_100_010), .VW(8), .VEC_BASE(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq), .nest_mode(mode), .cpu_ack(ack),
    .eoi(eoi), .cpu_req(req), .vector(vec), .err_sticky(err)
  );

  int tests = 0, fails = 0;

  // bench model: source 0 prio 2, source 1 prio 4, source 2 prio 5
  int m_prio [N] = '{2, 4, 5};
  logic [N-1:0] m_prev = '0, m_pend = '0;
  logic m_err = 1'b0;
  int m_arr[$];
  int m_stk[$];

  function automatic int m_pick(input logic md);
    int res, lvl;
    res = -1;
    if (md) begin
      lvl = (m_stk.size() > 0) ? m_prio[m_stk[m_stk.size()-1]] : 0;
      for (int p = lvl + 1; p < 8; p++)
        for (int s = N - 1; s >= 0; s--)
          if (m_pend[s] && m_prio[s] == p) res = s;
    end else if (m_stk.size() == 0 && m_arr.size() > 0) begin
      res = m_arr[0];
    end
    return res;
  endfunction

  function automatic void m_step(input logic [N-1:0] i, input logic md, input logic a, input logic e);
    int pk;
    pk = m_pick(md);
    if (e) begin
      if (m_stk.size() > 0) void'(m_stk.pop_back());
      else m_err = 1'b1;
    end
    if (a && pk >= 0) begin
      m_stk.push_back(pk);
      m_pend[pk] = 1'b0;
      for (int k = 0; k < m_arr.size(); k++)
        if (m_arr[k] == pk) begin m_arr.delete(k); break; end
    end
    for (int s = 0; s < N; s++)
      if (i[s] && !m_prev[s] && !m_pend[s]) begin
        m_pend[s] = 1'b1;
        m_arr.push_back(s);
      end
    m_prev = i;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock: drive at falling edge, read at the next falling edge
  task automatic cyc(input logic [N-1:0] i, input logic md, input logic a, input logic e);
    int p;
    irq = i; mode = md; ack = a; eoi = e;
    m_step(i, md, a, e);
    @(posedge clk);
    @(negedge clk);
    ack = 1'b0; eoi = 1'b0;
    p = m_pick(md);
    chk("R11 model cpu_req", int'(req), int'(p >= 0));
    chk("R3 model vector", int'(vec), (p >= 0) ? int'(BASE) + p : 0);
    chk("R10 model err_sticky", int'(err), int'(m_err));
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd5171));
    repeat (3) @(negedge clk);
    chk("R1 reset cpu_req", int'(req), 0);
    chk("R1 reset vector", int'(vec), 0);
    chk("R1 reset err", int'(err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset cpu_req", int'(req), 0);

    // nested mode
    cyc(3'b001, 1, 0, 0); chk("R2 printer rise req", int'(req), 1); chk("R3 printer vector", int'(vec), 'h20);
    cyc(3'b001, 1, 1, 0); chk("R9 held line no re-request", int'(req), 0);
    cyc(3'b101, 1, 0, 0); chk("R4 comm preempts printer", int'(req), 1); chk("R4 comm vector", int'(vec), 'h22);
    cyc(3'b101, 1, 1, 0);
    cyc(3'b111, 1, 0, 0); chk("R5 disk below comm waits", int'(req), 0);
    cyc(3'b111, 1, 0, 1); chk("R6 return to printer lets disk in", int'(req), 1); chk("R6 disk vector", int'(vec), 'h21);
    cyc(3'b111, 1, 1, 0);
    cyc(3'b000, 1, 0, 1);
    cyc(3'b001, 1, 0, 0); chk("R5 equal level waits", int'(req), 0);
    cyc(3'b001, 1, 0, 1); chk("R6 pop to idle offers printer", int'(req), 1); chk("R6 printer vector", int'(vec), 'h20);
    cyc(3'b001, 1, 1, 0);
    cyc(3'b000, 1, 0, 1);
    cyc(3'b000, 1, 0, 1); chk("R10 stray eoi sets err", int'(err), 1); chk("R10 no request", int'(req), 0);
    cyc(3'b000, 1, 0, 0); chk("R10 err stays", int'(err), 1);

    // sequential mode
    cyc(3'b000, 0, 1, 0);
    cyc(3'b001, 0, 0, 0); chk("R11 stray ack pushed nothing", int'(req), 1); chk("R11 vector", int'(vec), 'h20);
    cyc(3'b001, 0, 1, 0);
    cyc(3'b101, 0, 0, 0); chk("R7 comm held off", int'(req), 0);
    cyc(3'b111, 0, 0, 0); chk("R7 disk held off", int'(req), 0);
    cyc(3'b111, 0, 0, 1); chk("R8 first arrival first", int'(vec), 'h22);
    cyc(3'b111, 0, 1, 0); chk("R7 held while comm in service", int'(req), 0);
    cyc(3'b111, 0, 0, 1); chk("R8 second arrival next", int'(vec), 'h21);
    cyc(3'b000, 0, 1, 0);
    cyc(3'b000, 0, 0, 1); chk("R8 queue empty", int'(req), 0);
    cyc(3'b110, 0, 0, 0); chk("R8 same cycle lowest index", int'(vec), 'h21);
    cyc(3'b110, 0, 1, 0);
    cyc(3'b000, 0, 0, 1); chk("R8 same cycle second", int'(vec), 'h22);
    cyc(3'b000, 0, 1, 0);
    cyc(3'b000, 0, 0, 1);

    // random traffic against the model (R2 to R11)
    for (int n = 0; n < 4000; n++) begin
      logic [N-1:0] ni;
      logic nm;
      ni = irq;
      nm = mode;
      if ($urandom % 4 == 0) ni = N'($urandom % 8);
      if ($urandom % 60 == 0) nm = ~mode;
      cyc(ni, nm, logic'($urandom % 3 == 0), logic'($urandom % 5 == 0));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule